// File: doc/BRIEF.md
# Vector Length and Loop State Register Unit

This block holds the lengths that control a hardware element loop: the largest permitted vector length, the active vector length, the sub-vector group size, and a combined state word that also carries the loop's current element and sub-element offsets. A control-register path addresses one of four selections, applies a read, a write with a full-width register value, or a write with a 5-bit immediate. In the same cycle it returns the value that goes to the destination register and flags illegal values. The current fields are driven out continuously to the loop sequencer.

Length writes do not all behave alike. A vector-length write returns the length actually granted after clamping, not the previous one. A maximum-length write and a group-size write return the previous value. The combined state word holds both lengths minus one, which lets a length of 64 fit a 6-bit field. Every field is clamped against the others when the word is written, so a saved context restores to a consistent loop position.

Top module: `svlen_csr_unit`

## Requirements
- R1: After reset the maximum length is 64, the vector length is 1, the group size is 1 and all four offsets are 0.
- R2: A write of 0 or of more than 64 to the maximum length (sel 0) or vector length (sel 1) raises `csr_exc_o` in that cycle, returns 0 and changes no field.
- R3: A legal write to the vector length (sel 1) sets it to the smaller of the request and the maximum length, returns that new length, and sets both element offsets to 0.
- R4: A legal write to the maximum length (sel 0) stores the request and returns the previous maximum. A vector length above the new maximum drops to it, and element offsets above the new length minus one drop to that value; the vector length never exceeds the maximum.
- R5: The immediate form (op 2) requests the 5-bit immediate plus one, so immediate 0 requests 1 and immediate 31 requests 32. The register form (op 1) requests `csr_wdata_i`.
- R6: A write to the group size (sel 2) accepts 1 to 4 and returns the previous size, setting both sub-element offsets to 0. A request of 0 or above 4 raises `csr_exc_o`, returns 0 and changes nothing.
- R7: A state word read (sel 3) returns maximum minus one in bits 5:0, vector length minus one in 11:6, source offset in 17:12, destination offset in 23:18, group size minus one in 25:24, source sub-offset in 27:26, destination sub-offset in 29:28, and zeros above bit 29.
- R8: A state word write returns the previous word and never raises an exception. The maximum becomes field+1. The vector length becomes the smaller of its field+1 and the new maximum. Each element offset becomes the smaller of its field and the new length minus one, and each sub-offset the smaller of its field and the new group size minus one. Bits above 29 are ignored. In immediate form the word is the zero-extended immediate.
- R9: A read (op 0), the reserved op 3, or any cycle with `csr_valid_i` low changes no field. A read returns the selected value: exact lengths for sel 0 to 2, the packed word for sel 3. With `csr_valid_i` low the outputs are 0 and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| csr_valid_i | input | 1 | Access strobe |
| csr_sel_i | input | 2 | 0 maximum length, 1 vector length, 2 group size, 3 state word |
| csr_op_i | input | 2 | 0 read, 1 register write, 2 immediate write, 3 reserved (read) |
| csr_wdata_i | input | 64 | Register-form write value |
| csr_imm_i | input | 5 | Immediate-form field |
| csr_rdata_o | output | 64 | Value for the destination register, same cycle |
| csr_exc_o | output | 1 | Illegal value, same cycle |
| maxlen_o | output | 7 | Current maximum length (1..64) |
| vlen_o | output | 7 | Current vector length (1..64) |
| subvl_o | output | 3 | Current group size (1..4) |
| src_offs_o | output | 6 | Current source element offset |
| dst_offs_o | output | 6 | Current destination element offset |
| src_suboffs_o | output | 2 | Current source sub-element offset |
| dst_suboffs_o | output | 2 | Current destination sub-element offset |

## Verification
The clamps can interact in the same cycle. A state word write brings a new maximum, a vector length above it, and offsets above both. The length must then clamp against the incoming maximum, and the offsets against that freshly clamped length rather than the stored one. A maximum-length write that shrinks below the current length must likewise pull the length and offsets down together. Directed words with every field oversized provoke these cases, followed by a long stream of random accesses. The bench's behavioural model judges the returned value and exception in the access cycle and all seven fields at every following clock.

// File: rtl/svlen_pkg.sv
package svlen_pkg;

  typedef enum logic [1:0] {
    SEL_MAXLEN = 2'd0,
    SEL_VLEN   = 2'd1,
    SEL_SUBLEN = 2'd2,
    SEL_STATE  = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_WREG = 2'd1,
    OP_WIMM = 2'd2,
    OP_RSVD = 2'd3
  } csr_op_e;

endpackage

// File: rtl/svlen_rst_sync.sv
module svlen_rst_sync (
  input  logic clk,
  input  logic arst_ni,
  output logic srst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_no = sync_q[1];
endmodule

// File: rtl/svlen_len_legal.sv
// Forms the requested length from the register or immediate operand and
// flags values outside 1..LIMIT.
module svlen_len_legal #(
  parameter int XLEN  = 64,
  parameter int IMMW  = 5,
  parameter int LIMIT = 64,
  parameter int OUTW  = 7
) (
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [OUTW-1:0] len_o,
  output logic            bad_o
);
  logic [XLEN-1:0] req;

  always_comb begin
    if (use_imm_i) req = XLEN'(imm_i) + XLEN'(1);
    else           req = wdata_i;
    bad_o = (req == '0) || (req > XLEN'(LIMIT));
    len_o = OUTW'(req);
  end
endmodule

// File: rtl/svlen_state_codec.sv
// Packs the stored fields into the state word and unpacks an incoming word
// with every field clamped against the ones it depends on.
module svlen_state_codec #(
  parameter int XLEN = 64,
  parameter int FW   = 6,
  parameter int SW   = 2
) (
  input  logic [FW-1:0]   mvl_m1_i,
  input  logic [FW-1:0]   vl_m1_i,
  input  logic [FW-1:0]   src_i,
  input  logic [FW-1:0]   dst_i,
  input  logic [SW-1:0]   sv_m1_i,
  input  logic [SW-1:0]   ssv_i,
  input  logic [SW-1:0]   dsv_i,
  output logic [XLEN-1:0] word_o,
  input  logic [XLEN-1:0] word_i,
  output logic [FW-1:0]   mvl_m1_o,
  output logic [FW-1:0]   vl_m1_o,
  output logic [FW-1:0]   src_o,
  output logic [FW-1:0]   dst_o,
  output logic [SW-1:0]   sv_m1_o,
  output logic [SW-1:0]   ssv_o,
  output logic [SW-1:0]   dsv_o
);
  localparam int STW    = 4*FW + 3*SW;
  localparam int SV_LSB = 4*FW;

  logic [STW-1:0] packed_fields;
  logic [FW-1:0]  wide_in  [4];
  logic [SW-1:0]  narrow_in[3];

  assign packed_fields = {dsv_i, ssv_i, sv_m1_i, dst_i, src_i, vl_m1_i, mvl_m1_i};

  generate
    if (XLEN > STW) begin : g_pad
      logic unused_hi;
      assign word_o    = {{(XLEN-STW){1'b0}}, packed_fields};
      assign unused_hi = ^word_i[XLEN-1:STW];
    end else begin : g_nopad
      assign word_o = XLEN'(packed_fields);
    end

    for (genvar i = 0; i < 4; i++) begin : g_wide
      assign wide_in[i] = word_i[i*FW +: FW];
    end
    for (genvar j = 0; j < 3; j++) begin : g_narrow
      assign narrow_in[j] = word_i[SV_LSB + j*SW +: SW];
    end
  endgenerate

  always_comb begin
    mvl_m1_o = wide_in[0];
    vl_m1_o  = (wide_in[1] < wide_in[0]) ? wide_in[1] : wide_in[0];
    src_o    = (wide_in[2] < vl_m1_o) ? wide_in[2] : vl_m1_o;
    dst_o    = (wide_in[3] < vl_m1_o) ? wide_in[3] : vl_m1_o;
    sv_m1_o  = narrow_in[0];
    ssv_o    = (narrow_in[1] < sv_m1_o) ? narrow_in[1] : sv_m1_o;
    dsv_o    = (narrow_in[2] < sv_m1_o) ? narrow_in[2] : sv_m1_o;
  end
endmodule

// File: rtl/svlen_csr_unit.sv
module svlen_csr_unit
  import svlen_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int SUBMAX = 4,
  parameter int IMMW   = 5
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       csr_valid_i,
  input  logic [1:0]                 csr_sel_i,
  input  logic [1:0]                 csr_op_i,
  input  logic [XLEN-1:0]            csr_wdata_i,
  input  logic [IMMW-1:0]            csr_imm_i,
  output logic [XLEN-1:0]            csr_rdata_o,
  output logic                       csr_exc_o,
  output logic [$clog2(XLEN):0]      maxlen_o,
  output logic [$clog2(XLEN):0]      vlen_o,
  output logic [$clog2(SUBMAX):0]    subvl_o,
  output logic [$clog2(XLEN)-1:0]    src_offs_o,
  output logic [$clog2(XLEN)-1:0]    dst_offs_o,
  output logic [$clog2(SUBMAX)-1:0]  src_suboffs_o,
  output logic [$clog2(SUBMAX)-1:0]  dst_suboffs_o
);
  localparam int FW  = $clog2(XLEN);
  localparam int LW  = FW + 1;
  localparam int SW  = $clog2(SUBMAX);
  localparam int SVW = SW + 1;

  logic srst_n;

  // stored state, lengths minus one
  logic [FW-1:0] mvl_q, vl_q, src_q, dst_q;
  logic [SW-1:0] sv_q, ssv_q, dsv_q;
  logic [FW-1:0] mvl_d, vl_d, src_d, dst_d;
  logic [SW-1:0] sv_d, ssv_d, dsv_d;
  logic          upd_en;

  csr_sel_e sel;
  csr_op_e  op;
  logic     is_wr, use_imm;

  logic [LW-1:0]   len_req, cur_max, cur_vl, vl_grant;
  logic            len_bad;
  logic [SVW-1:0]  sub_req, cur_sub;
  logic            sub_bad;
  logic [FW-1:0]   mvl_new, vl_clip;

  logic [XLEN-1:0] st_word_rd, st_word_wr;
  logic [FW-1:0]   st_mvl, st_vl, st_src, st_dst;
  logic [SW-1:0]   st_sv, st_ssv, st_dsv;

  svlen_rst_sync u_rst (
    .clk     (clk),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  assign sel     = csr_sel_e'(csr_sel_i);
  assign op      = csr_op_e'(csr_op_i);
  assign is_wr   = (op == OP_WREG) || (op == OP_WIMM);
  assign use_imm = (op == OP_WIMM);

  svlen_len_legal #(
    .XLEN (XLEN), .IMMW (IMMW), .LIMIT (XLEN), .OUTW (LW)
  ) u_len_chk (
    .use_imm_i (use_imm),
    .wdata_i   (csr_wdata_i),
    .imm_i     (csr_imm_i),
    .len_o     (len_req),
    .bad_o     (len_bad)
  );

  svlen_len_legal #(
    .XLEN (XLEN), .IMMW (IMMW), .LIMIT (SUBMAX), .OUTW (SVW)
  ) u_sub_chk (
    .use_imm_i (use_imm),
    .wdata_i   (csr_wdata_i),
    .imm_i     (csr_imm_i),
    .len_o     (sub_req),
    .bad_o     (sub_bad)
  );

  assign st_word_wr = use_imm ? XLEN'(csr_imm_i) : csr_wdata_i;

  svlen_state_codec #(
    .XLEN (XLEN), .FW (FW), .SW (SW)
  ) u_codec (
    .mvl_m1_i (mvl_q),
    .vl_m1_i  (vl_q),
    .src_i    (src_q),
    .dst_i    (dst_q),
    .sv_m1_i  (sv_q),
    .ssv_i    (ssv_q),
    .dsv_i    (dsv_q),
    .word_o   (st_word_rd),
    .word_i   (st_word_wr),
    .mvl_m1_o (st_mvl),
    .vl_m1_o  (st_vl),
    .src_o    (st_src),
    .dst_o    (st_dst),
    .sv_m1_o  (st_sv),
    .ssv_o    (st_ssv),
    .dsv_o    (st_dsv)
  );

  // current exact values and derived candidates
  assign cur_max  = LW'(mvl_q) + LW'(1);
  assign cur_vl   = LW'(vl_q) + LW'(1);
  assign cur_sub  = SVW'(sv_q) + SVW'(1);
  assign vl_grant = (len_req < cur_max) ? len_req : cur_max;
  assign mvl_new  = FW'(len_req - LW'(1));
  assign vl_clip  = (vl_q < mvl_new) ? vl_q : mvl_new;

  // next state and response
  always_comb begin
    mvl_d       = mvl_q;
    vl_d        = vl_q;
    src_d       = src_q;
    dst_d       = dst_q;
    sv_d        = sv_q;
    ssv_d       = ssv_q;
    dsv_d       = dsv_q;
    csr_rdata_o = '0;
    csr_exc_o   = 1'b0;

    unique case (sel)
      SEL_MAXLEN: begin
        csr_rdata_o = XLEN'(cur_max);
        if (is_wr) begin
          csr_exc_o = len_bad;
          mvl_d     = mvl_new;
          vl_d      = vl_clip;
          src_d     = (src_q < vl_clip) ? src_q : vl_clip;
          dst_d     = (dst_q < vl_clip) ? dst_q : vl_clip;
        end
      end
      SEL_VLEN: begin
        if (is_wr) begin
          csr_exc_o   = len_bad;
          csr_rdata_o = XLEN'(vl_grant);
          vl_d        = FW'(vl_grant - LW'(1));
          src_d       = '0;
          dst_d       = '0;
        end else begin
          csr_rdata_o = XLEN'(cur_vl);
        end
      end
      SEL_SUBLEN: begin
        csr_rdata_o = XLEN'(cur_sub);
        if (is_wr) begin
          csr_exc_o = sub_bad;
          sv_d      = SW'(sub_req - SVW'(1));
          ssv_d     = '0;
          dsv_d     = '0;
        end
      end
      default: begin
        csr_rdata_o = st_word_rd;
        if (is_wr) begin
          mvl_d = st_mvl;
          vl_d  = st_vl;
          src_d = st_src;
          dst_d = st_dst;
          sv_d  = st_sv;
          ssv_d = st_ssv;
          dsv_d = st_dsv;
        end
      end
    endcase

    if (!csr_valid_i) begin
      csr_exc_o   = 1'b0;
      csr_rdata_o = '0;
    end else if (csr_exc_o) begin
      csr_rdata_o = '0;
    end
  end

  assign upd_en = csr_valid_i && is_wr && !csr_exc_o;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mvl_q <= FW'(XLEN - 1);
      vl_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      sv_q  <= '0;
      ssv_q <= '0;
      dsv_q <= '0;
    end else if (upd_en) begin
      mvl_q <= mvl_d;
      vl_q  <= vl_d;
      src_q <= src_d;
      dst_q <= dst_d;
      sv_q  <= sv_d;
      ssv_q <= ssv_d;
      dsv_q <= dsv_d;
    end
  end

  assign maxlen_o      = cur_max;
  assign vlen_o        = cur_vl;
  assign subvl_o       = cur_sub;
  assign src_offs_o    = src_q;
  assign dst_offs_o    = dst_q;
  assign src_suboffs_o = ssv_q;
  assign dst_suboffs_o = dsv_q;

endmodule

// File: rtl/svlen_csr_chk.sv
module svlen_csr_chk #(
  parameter int XLEN   = 64,
  parameter int SUBMAX = 4
) (
  input logic                      clk,
  input logic                      rst_ni,
  input logic                      csr_valid_i,
  input logic [1:0]                csr_sel_i,
  input logic [1:0]                csr_op_i,
  input logic [XLEN-1:0]           csr_rdata_o,
  input logic                      csr_exc_o,
  input logic [$clog2(XLEN):0]     maxlen_o,
  input logic [$clog2(XLEN):0]     vlen_o,
  input logic [$clog2(SUBMAX):0]   subvl_o,
  input logic [$clog2(XLEN)-1:0]   src_offs_o,
  input logic [$clog2(XLEN)-1:0]   dst_offs_o,
  input logic [$clog2(SUBMAX)-1:0] src_suboffs_o,
  input logic [$clog2(SUBMAX)-1:0] dst_suboffs_o
);
  localparam int FW  = $clog2(XLEN);
  localparam int LW  = FW + 1;
  localparam int SW  = $clog2(SUBMAX);
  localparam int STW = 4*FW + 3*SW;

  logic wr_op;
  assign wr_op = (csr_op_i == 2'd1) || (csr_op_i == 2'd2);

  assert_vlen_within_max_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (vlen_o >= LW'(1)) && (vlen_o <= maxlen_o) && (maxlen_o <= LW'(XLEN)));

  assert_exc_freezes_state_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_valid_i && csr_exc_o) |=> ($stable(maxlen_o) && $stable(vlen_o) && $stable(subvl_o)
      && $stable(src_offs_o) && $stable(dst_offs_o)));

  assert_vlen_returns_new_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_valid_i && csr_sel_i == 2'd1 && wr_op && !csr_exc_o)
      |=> (vlen_o == $past(csr_rdata_o[LW-1:0])) && (src_offs_o == '0) && (dst_offs_o == '0));

  assert_offsets_bounded_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (LW'(src_offs_o) < vlen_o) && (LW'(dst_offs_o) < vlen_o)
      && ({1'b0, src_suboffs_o} < subvl_o) && ({1'b0, dst_suboffs_o} < subvl_o));

  assert_state_write_no_exc_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_valid_i && csr_sel_i == 2'd3) |-> !csr_exc_o);

  assert_subvl_range_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (subvl_o >= 1) && (subvl_o <= SUBMAX));

  assert_state_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_valid_i && csr_sel_i == 2'd3) |-> (csr_rdata_o[XLEN-1:STW] == '0));

  assert_read_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!csr_valid_i || !wr_op) |=> ($stable(maxlen_o) && $stable(vlen_o) && $stable(subvl_o)
      && $stable(src_offs_o) && $stable(dst_offs_o)
      && $stable(src_suboffs_o) && $stable(dst_suboffs_o)));

endmodule

bind svlen_csr_unit svlen_csr_chk #(.XLEN(XLEN), .SUBMAX(SUBMAX)) chk_i (
  .clk           (clk),
  .rst_ni        (rst_ni),
  .csr_valid_i   (csr_valid_i),
  .csr_sel_i     (csr_sel_i),
  .csr_op_i      (csr_op_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_exc_o     (csr_exc_o),
  .maxlen_o      (maxlen_o),
  .vlen_o        (vlen_o),
  .subvl_o       (subvl_o),
  .src_offs_o    (src_offs_o),
  .dst_offs_o    (dst_offs_o),
  .src_suboffs_o (src_suboffs_o),
  .dst_suboffs_o (dst_suboffs_o)
);

// File: tb/svlen_csr_unit_tb_top.sv
`timescale 1ns/1ps
module svlen_csr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [1:0]  op = 2'd0;
  logic [63:0] wdata = '0;
  logic [4:0]  imm = '0;
  logic [63:0] rdata;
  logic        exc;
  logic [6:0]  maxlen, vlen;
  logic [2:0]  subvl;
  logic [5:0]  srco, dsto;
  logic [1:0]  ssub, dsub;

  always #4 clk = ~clk;

  svlen_csr_unit dut_i (
    .clk (clk), .rst_ni (rst_ni), .csr_valid_i (valid), .csr_sel_i (sel),
    .csr_op_i (op), .csr_wdata_i (wdata), .csr_imm_i (imm),
    .csr_rdata_o (rdata), .csr_exc_o (exc), .maxlen_o (maxlen), .vlen_o (vlen),
    .subvl_o (subvl), .src_offs_o (srco), .dst_offs_o (dsto),
    .src_suboffs_o (ssub), .dst_suboffs_o (dsub)
  );

  int n_chk = 0, n_fail = 0;
  bit armed = 0, done = 0;
  string last_tag = "R1";

  // reference model state (exact lengths)
  int m_mvl = 64, m_vl = 1, m_sv = 1, m_src = 0, m_dst = 0, m_ssv = 0, m_dsv = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint unsigned pack_model();
    return longint'(m_mvl - 1) | (longint'(m_vl - 1) << 6) | (longint'(m_src) << 12)
         | (longint'(m_dst) << 18) | (longint'(m_sv - 1) << 24)
         | (longint'(m_ssv) << 26) | (longint'(m_dsv) << 28);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // compare all fields every clock, away from the rising edge
  always @(negedge clk) begin
    if (armed) begin
      chk(maxlen == m_mvl, last_tag, "maxlen", maxlen, m_mvl);
      chk(vlen == m_vl, last_tag, "vlen", vlen, m_vl);
      chk(subvl == m_sv, last_tag, "subvl", subvl, m_sv);
      chk(srco == m_src && dsto == m_dst, last_tag, "elem offsets",
          {srco, dsto}, {m_src[5:0], m_dst[5:0]});
      chk(ssub == m_ssv && dsub == m_dsv, last_tag, "sub offsets",
          {ssub, dsub}, {m_ssv[1:0], m_dsv[1:0]});
    end
  end

  task automatic access(input int a, input int o, input logic [63:0] wd,
                        input int im, input bit v, input string tag);
    longint unsigned req, e_rd, w;
    bit e_exc, wr;
    int n_mvl, n_vl, n_sv, n_src, n_dst, n_ssv, n_dsv;
    @(negedge clk);
    valid = v; sel = a[1:0]; op = o[1:0]; wdata = wd; imm = im[4:0];
    last_tag = tag;
    #1;
    n_mvl = m_mvl; n_vl = m_vl; n_sv = m_sv; n_src = m_src; n_dst = m_dst;
    n_ssv = m_ssv; n_dsv = m_dsv;
    wr = (o == 1) || (o == 2);
    req = (o == 2) ? longint'(im + 1) : wd;
    e_exc = 0;
    e_rd = 0;
    case (a)
      0: begin
        e_rd = m_mvl;
        if (wr) begin
          if (req == 0 || req > 64) e_exc = 1;
          else begin
            n_mvl = int'(req);
            n_vl = imin(m_vl, n_mvl);
            n_src = imin(m_src, n_vl - 1);
            n_dst = imin(m_dst, n_vl - 1);
          end
        end
      end
      1: begin
        e_rd = m_vl;
        if (wr) begin
          if (req == 0 || req > 64) e_exc = 1;
          else begin
            n_vl = imin(int'(req), m_mvl);
            e_rd = n_vl;
            n_src = 0; n_dst = 0;
          end
        end
      end
      2: begin
        e_rd = m_sv;
        if (wr) begin
          if (req == 0 || req > 4) e_exc = 1;
          else begin
            n_sv = int'(req); n_ssv = 0; n_dsv = 0;
          end
        end
      end
      default: begin
        e_rd = pack_model();
        if (wr) begin
          w = (o == 2) ? longint'(im) : wd;
          n_mvl = int'(w[5:0]) + 1;
          n_vl  = imin(int'(w[11:6]) + 1, n_mvl);
          n_src = imin(int'(w[17:12]), n_vl - 1);
          n_dst = imin(int'(w[23:18]), n_vl - 1);
          n_sv  = int'(w[25:24]) + 1;
          n_ssv = imin(int'(w[27:26]), n_sv - 1);
          n_dsv = imin(int'(w[29:28]), n_sv - 1);
        end
      end
    endcase
    if (e_exc) e_rd = 0;
    if (!v) begin e_exc = 0; e_rd = 0; end
    chk(rdata == e_rd, tag, "rdata", rdata, e_rd);
    chk(exc == e_exc, tag, "exception", exc, e_exc);
    @(posedge clk);
    if (v && wr && !e_exc) begin
      m_mvl = n_mvl; m_vl = n_vl; m_sv = n_sv; m_src = n_src; m_dst = n_dst;
      m_ssv = n_ssv; m_dsv = n_dsv;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1;
    // R1 reset values via reads
    access(0, 0, 0, 0, 1, "R1");
    access(1, 0, 0, 0, 1, "R1");
    access(2, 0, 0, 0, 1, "R1");
    access(3, 0, 0, 0, 1, "R7");
    // R3 / R2
    access(1, 1, 64'd10, 0, 1, "R3");
    access(1, 1, 64'd100, 0, 1, "R2");
    access(1, 1, 64'd0, 0, 1, "R2");
    access(0, 1, 64'd0, 0, 1, "R2");
    access(0, 1, 64'd65, 0, 1, "R2");
    access(1, 1, 64'h1_0000_0005, 0, 1, "R2");
    access(1, 1, 64'd64, 0, 1, "R3");
    // R4 shrink max below current length
    access(0, 1, 64'd8, 0, 1, "R4");
    access(1, 2, 0, 31, 1, "R5");
    access(1, 2, 0, 0, 1, "R5");
    access(0, 2, 0, 3, 1, "R5");
    access(1, 1, 64'd3, 0, 1, "R3");
    // R8 oversize every field
    access(3, 1, {24'hAB, 8'hC0, 2'b01, 2'b11, 2'b10, 6'd5, 6'd50, 6'd40, 6'd19},
           0, 1, "R8");
    access(3, 0, 0, 0, 1, "R7");
    access(3, 1, {34'h0, 2'b11, 2'b11, 2'b11, 6'd63, 6'd63, 6'd63, 6'd63}, 0, 1, "R8");
    // R4 shrink max clamps offsets
    access(0, 1, 64'd10, 0, 1, "R4");
    // R3 length write clears offsets
    access(1, 1, 64'd7, 0, 1, "R3");
    // R6 group size
    access(2, 1, 64'd4, 0, 1, "R6");
    access(3, 1, {34'h0, 2'b11, 2'b11, 2'b11, 6'd2, 6'd2, 6'd9, 6'd9}, 0, 1, "R8");
    access(2, 1, 64'd5, 0, 1, "R6");
    access(2, 1, 64'd0, 0, 1, "R6");
    access(2, 2, 0, 1, 1, "R6");
    access(2, 2, 0, 7, 1, "R6");
    // R9 no-change paths
    access(1, 3, 64'd5, 9, 1, "R9");
    access(0, 1, 64'd2, 0, 0, "R9");
    access(3, 1, 64'h3FFF_FFFF, 0, 0, "R9");
    access(3, 0, 0, 0, 1, "R9");
    // R8 immediate form of state
    access(3, 2, 0, 5, 1, "R8");
    access(3, 2, 0, 31, 1, "R8");
    // random stream
    for (int k = 0; k < 400; k++) begin
      logic [63:0] wd;
      wd = ($urandom % 8 == 0) ? {$urandom, $urandom} : 64'($urandom % 80);
      access(int'($urandom % 4), int'($urandom % 4), wd, int'($urandom % 32),
             ($urandom % 10) != 0, "R9");
    end
    @(negedge clk);
    valid = 0;
    @(negedge clk);
    armed = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule